// File: doc/BRIEF.md
# Segmented Address Bounds Checker

This block turns a 32-bit virtual address into a physical address for one process. It uses a table of eight segment entries. The three highest address bits pick the entry. The other 29 bits are an offset that is added to the entry's base.

The sum is then checked three ways:
- against the entry's exclusive upper limit;
- for a carry out of the addition;
- against the entry's write permission.

The block answers one clock after the request. The answer is either the physical address or a trap with a cause code. A kernel loads the table through a write port. That port only accepts writes that come with a privilege flag.

A typical user is a small core or DMA engine that needs simple hardware isolation without paging. Each entry can describe a read-only code region or a read-write data or stack region. An entry can also be left invalid so that any access to it traps.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is `req_addr[31:29]`, and it selects one of eight independent entries. Each entry holds a 32-bit base, a 32-bit limit, a writable flag and a valid flag.
- R2: For a legal access, `rsp_paddr` equals the selected base plus `req_addr[28:0]`, taken modulo 2^32.
- R3: An access is legal only when base + offset < limit, compared unsigned. The limit is the first illegal location. An illegal access reports `rsp_trap`=1 and `rsp_cause`=1 (bounds).
- R4: If base + offset carries out of 32 bits, the access traps with cause 1.
- R5: An access to an entry whose valid flag is clear traps with cause 1. After reset, every entry is invalid.
- R6: A write (`req_wr`=1) to an entry whose writable flag is clear traps with cause 2 (permission). Reads of that entry are allowed. A bounds fault takes precedence over a permission fault.
- R7: When `cfg_we` and `cfg_priv` are both high, the entry named by `cfg_seg` is loaded. Requests from the next cycle onward see the new entry. A request in the same cycle sees the old entry.
- R8: When `cfg_we` is high and `cfg_priv` is low, the table is left unchanged and `cfg_err` is high for exactly the following cycle.
- R9: `rsp_vld` follows `req_vld` one cycle later. On a trap, `rsp_paddr` is 0. When there is no trap, `rsp_cause` is 0. When `rsp_vld` is low, `rsp_trap`, `rsp_cause` and `rsp_paddr` are all 0.
- R10: While `rst_n` is low, `rsp_vld`, `rsp_trap`, `rsp_cause`, `rsp_paddr` and `cfg_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Privilege flag that qualifies the table write |
| cfg_seg | input | 3 | Entry to load |
| cfg_base | input | 32 | Base to load |
| cfg_limit | input | 32 | Exclusive upper limit to load |
| cfg_writable | input | 1 | Writable flag to load |
| cfg_valid | input | 1 | Valid flag to load |
| cfg_err | output | 1 | Unprivileged write was rejected (previous cycle) |
| req_vld | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Virtual address |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| rsp_vld | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address, 0 on trap |
| rsp_trap | output | 1 | Access refused |
| rsp_cause | output | 2 | 0 = valid, 1 = bounds, 2 = permission |

## Verification
Every table entry can be read out through a lookup, so corruption of any field shows up one cycle after the next request to that segment:
- a wrong base appears as a shifted `rsp_paddr`;
- a wrong limit or a missing carry check moves the point where cause 1 starts;
- a lost valid or writable flag flips the cause between 0, 1 and 2.

The bench therefore aims accesses at the limit and at the 32-bit wrap. It also issues writes to read-only segments, and it probes the same segment in the cycle of a table load and in the cycle after it.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ADDR_W   = 32,
  parameter int SEG_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_priv,
  input  logic [SEG_BITS-1:0] cfg_seg,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [ADDR_W-1:0]   cfg_limit,
  input  logic                cfg_writable,
  input  logic                cfg_valid,
  output logic                cfg_err,
  input  logic                req_vld,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_wr,
  output logic                rsp_vld,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic                rsp_trap,
  output logic [1:0]          rsp_cause
);
  localparam int NSEG  = 1 << SEG_BITS;
  localparam int OFF_W = ADDR_W - SEG_BITS;
  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_BOUND = 2'd1;
  localparam logic [1:0] CAUSE_PERM  = 2'd2;

  logic [ADDR_W-1:0] base_q  [NSEG];
  logic [ADDR_W-1:0] limit_q [NSEG];
  logic [NSEG-1:0]   valid_q, wr_ok_q;

  logic              load;
  logic [SEG_BITS-1:0] seg;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W:0]   sum;
  logic              out_of_range;
  logic [1:0]        cause_d;

  assign load = cfg_we && cfg_priv;
  assign seg  = req_addr[ADDR_W-1 -: SEG_BITS];
  assign off  = req_addr[OFF_W-1:0];
  assign sum  = {1'b0, base_q[seg]} + {{(SEG_BITS+1){1'b0}}, off};
  assign out_of_range = sum[ADDR_W] || (sum[ADDR_W-1:0] >= limit_q[seg]);

  always_comb begin
    if (!valid_q[seg] || out_of_range) cause_d = CAUSE_BOUND;
    else if (req_wr && !wr_ok_q[seg])  cause_d = CAUSE_PERM;
    else                               cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      base_q[cfg_seg]  <= cfg_base;
      limit_q[cfg_seg] <= cfg_limit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      wr_ok_q <= '0;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= cfg_we && !cfg_priv;
      if (load) begin
        valid_q[cfg_seg] <= cfg_valid;
        wr_ok_q[cfg_seg] <= cfg_writable;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_cause <= CAUSE_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_vld   <= req_vld;
      rsp_trap  <= req_vld && (cause_d != CAUSE_NONE);
      rsp_cause <= req_vld ? cause_d : CAUSE_NONE;
      rsp_paddr <= (req_vld && cause_d == CAUSE_NONE) ? sum[ADDR_W-1:0] : '0;
    end
  end

  // R3
  below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && !rsp_trap |-> rsp_paddr < $past(limit_q[seg]));

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && !rsp_trap |-> rsp_paddr >= $past(base_q[seg]));

  // R5
  invalid_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && !$past(valid_q[seg]) |-> rsp_trap && rsp_cause == CAUSE_BOUND);

  // R6
  perm_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cause == CAUSE_PERM |-> $past(req_vld) && $past(req_wr));

  // R8
  unpriv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_priv |=> $stable(valid_q) && $stable(wr_ok_q) && cfg_err);

  // R9
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> rsp_vld && rsp_cause != CAUSE_NONE && rsp_paddr == '0);
endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/100ps
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_writable = 1'b0, cfg_valid = 1'b0;
  logic [2:0]  cfg_seg = '0;
  logic [31:0] cfg_base = '0, cfg_limit = '0;
  logic        cfg_err;
  logic        req_vld = 1'b0, req_wr = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_vld, rsp_trap;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_base [8];
  logic [31:0] m_limit[8];
  logic [7:0]  m_valid = '0, m_wr = '0;

  always #2.5 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_seg(cfg_seg),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_writable(cfg_writable), .cfg_valid(cfg_valid), .cfg_err(cfg_err),
    .req_vld(req_vld), .req_addr(req_addr), .req_wr(req_wr),
    .rsp_vld(rsp_vld), .rsp_paddr(rsp_paddr), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_cause(input logic [31:0] a, input logic w);
    logic [2:0]  s = a[31:29];
    logic [32:0] sm = {1'b0, m_base[s]} + {4'b0, a[28:0]};
    if (!m_valid[s] || sm[32] || sm[31:0] >= m_limit[s]) return 2'd1;
    if (w && !m_wr[s]) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [31:0] exp_paddr(input logic [31:0] a, input logic w);
    if (exp_cause(a, w) != 2'd0) return 32'd0;
    return m_base[a[31:29]] + {3'b0, a[28:0]};
  endfunction

  task automatic lookup(input string tag, input logic [31:0] a, input logic w);
    logic [1:0] ec = exp_cause(a, w);
    logic [31:0] ep = exp_paddr(a, w);
    req_vld = 1'b1; req_addr = a; req_wr = w;
    @(negedge clk);
    req_vld = 1'b0; req_wr = 1'b0;
    check({tag, " vld"}, 64'(rsp_vld), 64'd1);
    check({tag, " cause"}, 64'(rsp_cause), 64'(ec));
    check({tag, " trap"}, 64'(rsp_trap), 64'(ec != 2'd0));
    check({tag, " paddr"}, 64'(rsp_paddr), 64'(ep));
  endtask

  task automatic load(input logic [2:0] s, input logic [31:0] b, input logic [31:0] l,
                      input logic w, input logic v, input logic p);
    cfg_we = 1'b1; cfg_priv = p; cfg_seg = s; cfg_base = b; cfg_limit = l;
    cfg_writable = w; cfg_valid = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
    if (p) begin m_base[s] = b; m_limit[s] = l; m_wr[s] = w; m_valid[s] = v; end
    check(p ? "R7 cfg_err low" : "R8 cfg_err high", 64'(cfg_err), 64'(!p));
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5e6));
    for (int i = 0; i < 8; i++) begin m_base[i] = '0; m_limit[i] = '0; end
    repeat (3) @(negedge clk);
    // R10
    check("R10 rsp_vld", 64'(rsp_vld), 0);
    check("R10 rsp_trap", 64'(rsp_trap), 0);
    check("R10 rsp_cause", 64'(rsp_cause), 0);
    check("R10 rsp_paddr", 64'(rsp_paddr), 0);
    check("R10 cfg_err", 64'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 every entry invalid after reset
    for (int s = 0; s < 8; s++) lookup("R5 post-reset", {3'(s), 29'h10}, 1'b0);

    // R2 R3 R6 read-only segment 1
    load(3'd1, 32'h1000_0000, 32'h1000_1000, 1'b0, 1'b1, 1'b1);
    lookup("R2 base", {3'd1, 29'h0}, 1'b0);
    lookup("R3 last legal", {3'd1, 29'hFFF}, 1'b0);
    lookup("R3 at limit", {3'd1, 29'h1000}, 1'b0);
    lookup("R6 write ro", {3'd1, 29'h0}, 1'b1);
    lookup("R6 bound before perm", {3'd1, 29'h1000}, 1'b1);

    // R4 carry at top of space
    load(3'd7, 32'hFFFF_F000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1);
    lookup("R4 near top", {3'd7, 29'hFFE}, 1'b1);
    lookup("R4 carry", {3'd7, 29'h1000}, 1'b0);

    // R8 unprivileged write ignored
    load(3'd1, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
    lookup("R8 table unchanged", {3'd1, 29'h0}, 1'b1);
    lookup("R8 limit unchanged", {3'd1, 29'h2000}, 1'b0);

    // R7 same-cycle lookup sees old entry
    cfg_we = 1'b1; cfg_priv = 1'b1; cfg_seg = 3'd2; cfg_base = 32'h2000_0000;
    cfg_limit = 32'h2000_0100; cfg_writable = 1'b1; cfg_valid = 1'b1;
    req_vld = 1'b1; req_addr = {3'd2, 29'h4}; req_wr = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0; req_vld = 1'b0; req_wr = 1'b0;
    check("R7 old entry cause", 64'(rsp_cause), 64'd1);
    m_base[2] = 32'h2000_0000; m_limit[2] = 32'h2000_0100; m_wr[2] = 1'b1; m_valid[2] = 1'b1;
    lookup("R7 new entry", {3'd2, 29'h4}, 1'b1);

    // R9 idle cycle
    @(negedge clk);
    check("R9 idle vld", 64'(rsp_vld), 0);
    check("R9 idle trap", 64'(rsp_trap), 0);
    check("R9 idle paddr", 64'(rsp_paddr), 0);

    // R1 distinct entries
    for (int s = 0; s < 8; s++)
      load(3'(s), 32'(s) * 32'h0100_0000 + 32'h40, 32'(s) * 32'h0100_0000 + 32'h140, 1'(s % 2), 1'b1, 1'b1);
    for (int s = 0; s < 8; s++) lookup("R1 select", {3'(s), 29'h10}, 1'b0);

    // R2 R3 R4 R6 R7 R8 random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 5 == 0) begin
        logic [31:0] b = $urandom;
        if ($urandom % 3 == 0) b = b | 32'hFFFF_0000;
        load(3'($urandom), b, b + ($urandom % 8192) - 32'd64,
             1'($urandom), ($urandom % 8) != 0, ($urandom % 7) != 0);
      end else begin
        logic [2:0]  s = 3'($urandom);
        logic [31:0] span = (m_limit[s] > m_base[s]) ? m_limit[s] - m_base[s] : 32'd16;
        logic [31:0] o = ($urandom % 4 == 0) ? $urandom : ($urandom % (span + 32'd32));
        lookup("R3 random", {s, o[28:0]}, 1'($urandom));
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule